// File: doc/BRIEF.md
# Single-Step Clock Gating Controller

This block turns a free-running input clock into the gated system clock of a small processor core. It takes three push-button inputs (Go, Single-Step and Halt) and a halt request that the core raises while it executes a halt instruction. From these it keeps a halt state bit. While the core runs, the system clock follows the input clock. While it is halted, each press of Single-Step yields exactly one high phase of the system clock, half an input period long.

A step pulse is built without a counter. A toggle bit flips once per qualified step. Two flip-flops sample that bit, one on each edge of the input clock, and their XOR is high for the half period between them. Go clears the halt bit and also flips the toggle. So when the core sits on a halt instruction whose request stays asserted, Go still moves it forward by one clock. The request is ignored in the cycle in which Go takes effect.

Top module: `stepclk_gate`

## Requirements
- R1: After reset the halt bit `halted` is 1 and `sys_clk` stays low until a button is pressed.
- R2: While halted, each press of `step_btn` gives exactly one rising edge on `sys_clk`, and its high phase lasts half an input clock period.
- R3: A step press held for several cycles gives one pulse only, and releasing the button gives none. Only the rising edge of the button counts.
- R4: `step_btn` has no effect while the block is running. The number of `sys_clk` edges still equals the number of `clk_in` edges.
- R5: A press of `go_btn` clears `halted`. After it, `sys_clk` has one rising edge for every rising edge of `clk_in`.
- R6: A press of `halt_btn` sets `halted`, and `sys_clk` then stops with no further rising edges. Any high phase that has begun runs to its full width.
- R7: A one-cycle `halt_req` from the core sets `halted` at the next rising edge of `clk_in`.
- R8: A Go press while `halt_req` is held gives exactly one `sys_clk` pulse of half a period, and the block is halted again afterwards.
- R9: When Go and Halt are pressed in the same cycle, Go wins and the block ends up running.
- R10: Each button passes through a `SYNC_STAGES`-deep synchronizer, and one press acts once however long it is held. A Go held for many cycles against a held `halt_req` still gives one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_btn | input | 1 | Go button, asynchronous level |
| step_btn | input | 1 | Single-Step button, asynchronous level |
| halt_btn | input | 1 | Halt button, asynchronous level |
| halt_req | input | 1 | Halt request from the core, synchronous to `clk_in` |
| sys_clk | output | 1 | Gated system clock |
| halted | output | 1 | Halt state bit |

## Verification
The assertions check the following on every rising edge of the input clock:
- the step pulse is always low at that edge;
- Go clears the halt bit and flips the toggle;
- the Halt button or the request sets the halt bit unless Go coincides;
- the toggle holds still while the block runs.

Pulse counts and high-phase widths of the gated output can only be shown by the bench's scenarios. These include:
- sweeps over step press lengths and gaps;
- edge counting while the block runs;
- the escape from a held halt request.

// File: rtl/stepclk_gate.sv
module stepclk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic go_btn,
  input  logic step_btn,
  input  logic halt_btn,
  input  logic halt_req,
  output logic sys_clk,
  output logic halted
);

  localparam int SHW = SYNC_STAGES + 1;

  logic [SHW-1:0] go_sh, step_sh, halt_sh;
  logic go_rise, step_rise, halt_rise;
  logic tog, samp_pos, samp_neg, pulse, run_en;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      go_sh   <= '0;
      step_sh <= '0;
      halt_sh <= '0;
    end else begin
      go_sh   <= {go_sh[SHW-2:0], go_btn};
      step_sh <= {step_sh[SHW-2:0], step_btn};
      halt_sh <= {halt_sh[SHW-2:0], halt_btn};
    end

  assign go_rise   = go_sh[SHW-2]   & ~go_sh[SHW-1];
  assign step_rise = step_sh[SHW-2] & ~step_sh[SHW-1];
  assign halt_rise = halt_sh[SHW-2] & ~halt_sh[SHW-1];

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n)                     halted <= 1'b1;
    else if (go_rise)               halted <= 1'b0;
    else if (halt_rise || halt_req) halted <= 1'b1;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n)                           tog <= 1'b0;
    else if (go_rise || (halted && step_rise)) tog <= ~tog;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) samp_pos <= 1'b0;
    else        samp_pos <= tog;

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) samp_neg <= 1'b0;
    else        samp_neg <= samp_pos;

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) run_en <= 1'b0;
    else        run_en <= ~halted;

  assign pulse   = samp_pos ^ samp_neg;
  assign sys_clk = run_en ? clk_in : pulse;

  p_pulse_low_at_rise_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    !pulse);

  p_step_still_running_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!halted && !go_rise) |=> $stable(tog));

  p_go_clears_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    go_rise |=> !halted);

  p_go_steps_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    go_rise |=> (tog != $past(tog)));

  p_halt_sets_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (halt_rise && !go_rise) |=> halted);

  p_req_sets_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (halt_req && !go_rise) |=> halted);

endmodule

// File: tb/tb_stepclk_gate.sv
`timescale 1ns/1ps
module tb_stepclk_gate;
  localparam int P = 10;

  logic clk_in = 0, rst_n = 0;
  logic go_btn = 0, step_btn = 0, halt_btn = 0, halt_req = 0;
  logic sys_clk, halted;

  int vectors = 0, miscompares = 0, edges = 0;
  realtime rise_t = 0, last_w = 0;
  bit done = 0;

  stepclk_gate dut (.clk_in(clk_in), .rst_n(rst_n), .go_btn(go_btn), .step_btn(step_btn),
                    .halt_btn(halt_btn), .halt_req(halt_req), .sys_clk(sys_clk), .halted(halted));

  always #(P/2) clk_in = ~clk_in;

  always @(posedge sys_clk) begin edges++; rise_t = $realtime; end
  always @(negedge sys_clk) last_w = $realtime - rise_t;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_in);
    #(P/4);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_over(input string req, input int n, input int exp);
    int base = edges;
    cyc(n);
    chk(req, edges - base, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(P * 150000);
    miscompares++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int base;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 halted", halted, 1);
    chk("R1 sys_clk low", sys_clk, 0);
    count_over("R1 idle edges", 10, 0);

    // R2 R3 sweep: n presses of length len and gap gap
    for (int n = 1; n <= 4; n++)
      for (int len = 1; len <= 4; len++)
        for (int gap = 1; gap <= 3; gap++) begin
          base = edges;
          for (int k = 0; k < n; k++) begin
            step_btn = 1; cyc(len);
            step_btn = 0; cyc(gap);
          end
          cyc(6);
          chk("R2 R3 step pulses", edges - base, n);
          chk("R2 pulse width", int'(last_w * 100), P * 50);
          chk("R1 still halted", halted, 1);
        end

    // R5 Go to run
    go_btn = 1; cyc(2); go_btn = 0; cyc(6);
    chk("R5 halted cleared", halted, 0);
    count_over("R5 follows clk_in", 20, 20);
    chk("R5 width", int'(last_w * 100), P * 50);

    // R4 steps ignored while running
    base = edges;
    for (int k = 0; k < 3; k++) begin step_btn = 1; cyc(2); step_btn = 0; cyc(2); end
    chk("R4 step ignored running", edges - base, 12);
    chk("R4 still running", halted, 0);

    // R6 halt button
    halt_btn = 1; cyc(2); halt_btn = 0; cyc(6);
    chk("R6 halted set", halted, 1);
    count_over("R6 clock stopped", 20, 0);
    chk("R6 last high phase full", int'(last_w * 100), P * 50);

    // R9 Go and Halt together while halted
    go_btn = 1; halt_btn = 1; cyc(1); go_btn = 0; halt_btn = 0; cyc(6);
    chk("R9 go wins from halted", halted, 0);
    go_btn = 1; halt_btn = 1; cyc(1); go_btn = 0; halt_btn = 0; cyc(6);
    chk("R9 go wins while running", halted, 0);
    count_over("R9 running edges", 10, 10);

    // R7 single-cycle halt request
    halt_req = 1; cyc(1); halt_req = 0;
    chk("R7 halted after req", halted, 1);
    cyc(3);
    count_over("R7 clock stopped", 15, 0);

    // R8 R10 Go against held halt request, several hold lengths
    halt_req = 1;
    for (int hold = 1; hold <= 8; hold += 3) begin
      base = edges;
      go_btn = 1; cyc(hold); go_btn = 0; cyc(10);
      chk("R8 R10 one escape pulse", edges - base, 1);
      chk("R8 width", int'(last_w * 100), P * 50);
      chk("R8 halted again", halted, 1);
    end
    halt_req = 0;
    go_btn = 1; cyc(2); go_btn = 0; cyc(6);
    chk("R5 run after req released", halted, 0);
    count_over("R5 run edges", 20, 20);

    finish_run();
  end
endmodule